// File: doc/BRIEF.md
# Touch panel scan sequencer

This block is the host side of a resistive touch panel front end. It drives a serial analog-to-digital touch converter through a chip-select framed synchronous serial port, with the serial clock derived from the system clock by a fixed divider. After reset it sends one command that leaves the converter's internal reference switched off and arms pen detection. It then waits for the active-low pen-detect line.

When the pen-detect line is asserted, it runs four ratiometric (differential reference) measurements in a fixed order: X position, Y position, and the two pressure readings Z1 and Z2. Each measurement is one framed transfer: an eight-bit command is shifted out, and the 12-bit result is shifted in, MSB first. The four raw readings are presented together as one record with a one-cycle valid strobe. The record also carries a flag that tells whether the pen had already lifted when the scan ended.

The pen-detect line is not looked at while a transfer is in progress. It is also ignored for a programmable number of cycles after each command sequence, so that the panel can settle before pen detection is trusted again.

Top module: `touch_scan_seq`

## Requirements
- R1: After reset `ssel_no` is 1, `sck_o` is 0 and `rec_valid_o` is 0. The first frame after reset carries command 0xD0: start bit 1, channel 101, 12-bit mode, differential reference and power code 00, so the converter's reference is off.
- R2: Each frame holds `ssel_no` low across exactly 24 rising edges of `sck_o`, and `sck_o` is low whenever `ssel_no` is high. The command goes out MSB first on `mosi_o`, which changes only while `sck_o` is low.
- R3: Every high phase and every low phase of `sck_o` inside a frame lasts at least DIV_HALF system cycles (40 cycles, 200 ns at 200 MHz). This includes the low phase between `ssel_no` falling and the first rising edge.
- R4: A scan begins only when the synchronized `pen_det_ni` is low. While that line stays high no frame is started.
- R5: A scan sends four commands in this order: 0xD1 (X, channel 101), 0x91 (Y, channel 001), 0xB1 (Z1, channel 011) and 0xC0 (Z2, channel 100). The bit layout is [7] start=1, [6:4] channel, [3] mode=0 for 12 bits, [2]=0 for differential, [1:0] power code. The power code is 01 on the first three commands and 00 on the last.
- R6: The result of a frame is the value of `miso_i` sampled on rising edges 10 through 21 of that frame, MSB first. Levels on all other edges have no effect on the result.
- R7: After the Z2 frame ends, `rec_valid_o` pulses for one cycle while `ssel_no` is high, with the X, Y, Z1 and Z2 results on `rec_x_o`, `rec_y_o`, `rec_z1_o` and `rec_z2_o`. These outputs hold their values until the next record.
- R8: `rec_pen_up_o` is the synchronized `pen_det_ni` level at the moment the scan completes: 1 means the pen had lifted, 0 means it was still touching.
- R9: Changes on `pen_det_ni` while `ssel_no` is low neither abort nor restart a scan.
- R10: After the reset command and after every scan, `pen_det_ni` is ignored for `settle_cycles_i` cycles. With the pen held down, the next scan's `ssel_no` falls exactly `settle_cycles_i`+1 cycles after `rec_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pen_det_ni | input | 1 | Pen-detect line from the converter, low while touched (asynchronous) |
| settle_cycles_i | input | SETTLE_W | Number of cycles pen detection is ignored after each command sequence |
| ssel_no | output | 1 | Frame select to the converter, active low |
| sck_o | output | 1 | Serial clock to the converter |
| mosi_o | output | 1 | Command data to the converter |
| miso_i | input | 1 | Result data from the converter |
| rec_valid_o | output | 1 | One-cycle strobe: a new record is on the outputs |
| rec_x_o | output | RES_W | X reading |
| rec_y_o | output | RES_W | Y reading |
| rec_z1_o | output | RES_W | Z1 reading |
| rec_z2_o | output | RES_W | Z2 reading |
| rec_pen_up_o | output | 1 | Pen had lifted when the scan completed |

## Verification
A wrong measurement index or sequencer state shows up at the end of the very next frame. The captured command byte then differs from the expected X, Y, Z1, Z2 order, or a record arrives with its fields shifted. A result window that is off by one edge corrupts the record within the same scan, because the converter model drives ones outside the window and the test values include 0x000 and 0xFFF. A settle counter or pen gate that is wrong is visible as a frame select edge that comes early, late, or during a window that should stay quiet; the bench measures that edge to the exact cycle.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
package tsc_pkg;

  localparam int unsigned CMD_W          = 8;
  localparam int unsigned FRAME_CLKS     = 24;
  localparam int unsigned RES_FIRST_RISE = 10;  // first rising edge after the busy clock
  localparam int unsigned MEAS_N         = 4;
  localparam int unsigned IDX_W          = $clog2(MEAS_N);

  typedef enum logic [2:0] {
    CH_Y  = 3'b001,
    CH_Z1 = 3'b011,
    CH_Z2 = 3'b100,
    CH_X  = 3'b101
  } chan_e;

  typedef enum logic [1:0] {
    PD_IRQ_ON  = 2'b00,  // sleep between conversions, pen detect live, reference off
    PD_REF_OFF = 2'b01
  } pwr_e;

  typedef enum logic [1:0] {
    SQ_BOOT,
    SQ_INIT,
    SQ_ARM,
    SQ_SCAN
  } seq_e;

  function automatic logic [CMD_W-1:0] make_cmd(chan_e ch, pwr_e pw);
    // start, channel, 12-bit mode, differential reference, power code
    return {1'b1, ch, 1'b0, 1'b0, pw};
  endfunction

  function automatic chan_e meas_chan(logic [IDX_W-1:0] idx);
    case (idx)
      2'd0:    return CH_X;
      2'd1:    return CH_Y;
      2'd2:    return CH_Z1;
      default: return CH_Z2;
    endcase
  endfunction

endpackage

// File: rtl/tsc_tick_gen.sv
`timescale 1ns/1ps
module tsc_tick_gen #(
  parameter int unsigned DIV_HALF = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tsc_pen_sync.sv
`timescale 1ns/1ps
module tsc_pen_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pen_ni,
  output logic pen_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;  // idle level: no pen
    else         sync_q <= {sync_q[STAGES-2:0], pen_ni};
  end

  assign pen_o = sync_q[STAGES-1];
endmodule

// File: rtl/tsc_xfer.sv
`timescale 1ns/1ps
module tsc_xfer import tsc_pkg::*; #(
  parameter int unsigned DIV_HALF = 40,
  parameter int unsigned RES_W    = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             miso_i,
  output logic             ssel_no,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             done_o,
  output logic [RES_W-1:0] data_o
);
  localparam int unsigned RISE_W = $clog2(FRAME_CLKS + 1);
  localparam logic [RISE_W-1:0] LAST_RISE = RISE_W'(FRAME_CLKS);
  localparam logic [RISE_W-1:0] SAMP_LO   = RISE_W'(RES_FIRST_RISE - 1);
  localparam logic [RISE_W-1:0] SAMP_HI   = RISE_W'(RES_FIRST_RISE - 1 + RES_W);

  logic              busy_q, sck_q, ssel_nq, mosi_q, done_q, tick;
  logic [RISE_W-1:0] rise_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [RES_W-1:0]  res_q;
  logic              in_window;

  tsc_tick_gen #(.DIV_HALF(DIV_HALF)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (busy_q),
    .tick_o(tick)
  );

  assign in_window = (rise_q >= SAMP_LO) && (rise_q < SAMP_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sck_q   <= 1'b0;
      ssel_nq <= 1'b1;
      mosi_q  <= 1'b0;
      done_q  <= 1'b0;
      rise_q  <= '0;
      cmd_q   <= '0;
      res_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          ssel_nq <= 1'b0;
          mosi_q  <= cmd_i[CMD_W-1];
          cmd_q   <= {cmd_i[CMD_W-2:0], 1'b0};
          rise_q  <= '0;
        end
      end else if (tick) begin
        if (sck_q) begin
          // falling edge: present next command bit, zeros after the byte
          sck_q  <= 1'b0;
          mosi_q <= cmd_q[CMD_W-1];
          cmd_q  <= {cmd_q[CMD_W-2:0], 1'b0};
        end else if (rise_q == LAST_RISE) begin
          busy_q  <= 1'b0;
          ssel_nq <= 1'b1;
          mosi_q  <= 1'b0;
          done_q  <= 1'b1;
        end else begin
          sck_q  <= 1'b1;
          rise_q <= rise_q + 1'b1;
          if (in_window) res_q <= {res_q[RES_W-2:0], miso_i};
        end
      end
    end
  end

  assign ssel_no = ssel_nq;
  assign sck_o   = sck_q;
  assign mosi_o  = mosi_q;
  assign done_o  = done_q;
  assign data_o  = res_q;
endmodule

// File: rtl/touch_scan_seq.sv
`timescale 1ns/1ps
module touch_scan_seq import tsc_pkg::*; #(
  parameter int unsigned DIV_HALF    = 40,
  parameter int unsigned RES_W       = 12,
  parameter int unsigned SETTLE_W    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pen_det_ni,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  output logic                ssel_no,
  output logic                sck_o,
  output logic                mosi_o,
  input  logic                miso_i,
  output logic                rec_valid_o,
  output logic [RES_W-1:0]    rec_x_o,
  output logic [RES_W-1:0]    rec_y_o,
  output logic [RES_W-1:0]    rec_z1_o,
  output logic [RES_W-1:0]    rec_z2_o,
  output logic                rec_pen_up_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MEAS_N - 1);

  seq_e                state_q;
  logic [IDX_W-1:0]    idx_q, nxt_idx;
  logic [SETTLE_W-1:0] settle_q;
  logic [RES_W-1:0]    slot_q [MEAS_N];
  logic [RES_W-1:0]    rec_q  [MEAS_N];
  logic                rec_valid_q, pen_up_q;
  logic                pen_lvl, arm_go, xfer_start, xfer_done;
  logic [CMD_W-1:0]    xfer_cmd;
  logic [RES_W-1:0]    xfer_data;

  tsc_pen_sync #(.STAGES(SYNC_STAGES)) i_pen_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pen_ni(pen_det_ni),
    .pen_o (pen_lvl)
  );

  tsc_xfer #(.DIV_HALF(DIV_HALF), .RES_W(RES_W)) i_xfer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(xfer_start),
    .cmd_i  (xfer_cmd),
    .miso_i (miso_i),
    .ssel_no(ssel_no),
    .sck_o  (sck_o),
    .mosi_o (mosi_o),
    .done_o (xfer_done),
    .data_o (xfer_data)
  );

  // pen is only looked at in SQ_ARM, where the bus is idle
  assign arm_go = (state_q == SQ_ARM) && (settle_q == '0) && !pen_lvl;
  assign xfer_start = (state_q == SQ_BOOT) || arm_go ||
                      ((state_q == SQ_SCAN) && xfer_done && (idx_q != LAST_IDX));

  always_comb begin
    nxt_idx = arm_go ? '0 : idx_q + 1'b1;
    if (state_q == SQ_BOOT)
      xfer_cmd = make_cmd(CH_X, PD_IRQ_ON);
    else
      xfer_cmd = make_cmd(meas_chan(nxt_idx),
                          (nxt_idx == LAST_IDX) ? PD_IRQ_ON : PD_REF_OFF);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SQ_BOOT;
      idx_q       <= '0;
      settle_q    <= '0;
      rec_valid_q <= 1'b0;
      pen_up_q    <= 1'b0;
      for (int i = 0; i < MEAS_N; i++) begin
        slot_q[i] <= '0;
        rec_q[i]  <= '0;
      end
    end else begin
      rec_valid_q <= 1'b0;
      case (state_q)
        SQ_BOOT: state_q <= SQ_INIT;
        SQ_INIT: begin
          if (xfer_done) begin
            settle_q <= settle_cycles_i;
            state_q  <= SQ_ARM;
          end
        end
        SQ_ARM: begin
          if (settle_q != '0) settle_q <= settle_q - 1'b1;
          else if (!pen_lvl) begin
            idx_q   <= '0;
            state_q <= SQ_SCAN;
          end
        end
        SQ_SCAN: begin
          if (xfer_done) begin
            if (idx_q == LAST_IDX) begin
              for (int i = 0; i < MEAS_N - 1; i++) rec_q[i] <= slot_q[i];
              rec_q[MEAS_N-1] <= xfer_data;
              pen_up_q        <= pen_lvl;
              rec_valid_q     <= 1'b1;
              settle_q        <= settle_cycles_i;
              state_q         <= SQ_ARM;
            end else begin
              slot_q[idx_q] <= xfer_data;
              idx_q         <= idx_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign rec_valid_o  = rec_valid_q;
  assign rec_x_o      = rec_q[0];
  assign rec_y_o      = rec_q[1];
  assign rec_z1_o     = rec_q[2];
  assign rec_z2_o     = rec_q[3];
  assign rec_pen_up_o = pen_up_q;
endmodule

// File: rtl/tsc_checker.sv
`timescale 1ns/1ps
module tsc_checker #(
  parameter int unsigned DIV_HALF = 40,
  parameter int unsigned RES_W    = 12,
  parameter int unsigned SETTLE_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ssel_no,
  input logic                sck_o,
  input logic                mosi_o,
  input logic                rec_valid_o,
  input logic [RES_W-1:0]    rec_x_o,
  input logic [SETTLE_W-1:0] settle_cycles_i
);
  localparam int unsigned RUN_W = $clog2(DIV_HALF + 1) + 1;
  localparam logic [RUN_W-1:0] MIN_RUN = RUN_W'(DIV_HALF);

  logic              last_q, armed_q;
  logic [RUN_W-1:0]  run_q;
  logic [SETTLE_W:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q  <= 1'b0;
      run_q   <= '0;
      armed_q <= 1'b0;
      gap_q   <= '0;
    end else begin
      last_q <= sck_o;
      if (sck_o != last_q)  run_q <= RUN_W'(1);
      else if (run_q != '1) run_q <= run_q + 1'b1;
      if (rec_valid_o) begin
        armed_q <= 1'b1;
        gap_q   <= '0;
      end else if (!ssel_no) armed_q <= 1'b0;
      else if (gap_q != '1)  gap_q <= gap_q + 1'b1;
    end
  end

  AST_IDLE_SCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ssel_no |-> !sck_o);  // R2
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && last_q) |-> $stable(mosi_o));  // R2
  AST_HALF_PERIOD_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o != last_q) |-> (run_q >= MIN_RUN));  // R3
  AST_REC_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |=> !rec_valid_o);  // R7
  AST_REC_BUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> ssel_no);  // R7
  AST_REC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rec_valid_o |-> $stable(rec_x_o));  // R7
  AST_SETTLE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !ssel_no) |-> (gap_q >= {1'b0, settle_cycles_i}));  // R10
endmodule

bind touch_scan_seq tsc_checker #(
  .DIV_HALF(DIV_HALF),
  .RES_W   (RES_W),
  .SETTLE_W(SETTLE_W)
) i_tsc_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ssel_no        (ssel_no),
  .sck_o          (sck_o),
  .mosi_o         (mosi_o),
  .rec_valid_o    (rec_valid_o),
  .rec_x_o        (rec_x_o),
  .settle_cycles_i(settle_cycles_i)
);

// File: tb/test_touch_scan_seq.sv
`timescale 1ns/1ps
module test_touch_scan_seq;
  localparam int DIV_HALF = 40;
  localparam int RES_W    = 12;
  localparam int SETTLE_W = 16;

  typedef struct {int x; int y; int z1; int z2; int pu;} rec_t;

  logic clk = 1'b0, rst_n = 1'b0, pen_n = 1'b1, miso = 1'b1;
  logic [SETTLE_W-1:0] settle = 16'd20;
  logic ssel_n, sck, mosi, rec_valid, rec_pu;
  logic [RES_W-1:0] rec_x, rec_y, rec_z1, rec_z2;

  int cyc = 0, n_cmp = 0, n_err = 0;
  int n_frames = 0, n_recs = 0, rec_cyc = 0;
  bit frames_on = 0;
  logic [7:0] exp_cmd_q[$];
  rec_t exp_rec_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  touch_scan_seq #(.DIV_HALF(DIV_HALF), .RES_W(RES_W), .SETTLE_W(SETTLE_W)) i_touch_scan_seq (
    .clk_i(clk), .rst_ni(rst_n), .pen_det_ni(pen_n), .settle_cycles_i(settle),
    .ssel_no(ssel_n), .sck_o(sck), .mosi_o(mosi), .miso_i(miso),
    .rec_valid_o(rec_valid), .rec_x_o(rec_x), .rec_y_o(rec_y),
    .rec_z1_o(rec_z1), .rec_z2_o(rec_z2), .rec_pen_up_o(rec_pu)
  );

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // converter model: captures the command, drives ones outside the result window
  int rise_n = 0;
  logic [7:0] cap_cmd = '0;
  logic [11:0] chan_val [8];

  always @(negedge ssel_n) begin
    rise_n = 0;
    cap_cmd = '0;
    miso <= 1'b1;
  end
  always @(posedge sck) if (!ssel_n) begin
    rise_n++;
    if (rise_n <= 8) cap_cmd = {cap_cmd[6:0], mosi};
  end
  always @(negedge sck) if (!ssel_n) begin
    if (rise_n >= 9 && rise_n <= 20) miso <= chan_val[cap_cmd[6:4]][20 - rise_n];
    else miso <= 1'b1;
  end

  // frame monitor: command byte and clock count
  always @(posedge ssel_n) if (frames_on) begin
    n_frames++;
    check("R2 rising edges per frame", rise_n, 24);
    if (exp_cmd_q.size() == 0) check("R4 R5 unexpected frame", 1, 0);
    else check("R1 R5 command byte", cap_cmd, exp_cmd_q.pop_front());
  end

  // record monitor
  always @(negedge clk) if (rst_n && rec_valid) begin
    rec_t e;
    n_recs++;
    rec_cyc = cyc;
    if (exp_rec_q.size() == 0) check("R7 unexpected record", 1, 0);
    else begin
      e = exp_rec_q.pop_front();
      check("R6 R7 x field", rec_x, e.x);
      check("R6 R7 y field", rec_y, e.y);
      check("R6 R7 z1 field", rec_z1, e.z1);
      check("R6 R7 z2 field", rec_z2, e.z2);
      check("R8 pen-up flag", rec_pu, e.pu);
    end
  end

  // shortest sck phase inside frames
  int min_run = 1000000, run = 0;
  logic prev_sck = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !ssel_n) begin
      if (sck == prev_sck) run++;
      else begin
        if (run < min_run) min_run = run;
        run = 1;
      end
      prev_sck = sck;
    end else begin
      run = 0;
      prev_sck = 1'b0;
    end
  end

  task automatic set_vals(int x, int y, int z1, int z2);
    chan_val[5] = 12'(x); chan_val[1] = 12'(y);
    chan_val[3] = 12'(z1); chan_val[4] = 12'(z2);
  endtask

  task automatic push_scan(int x, int y, int z1, int z2, int pu);
    rec_t r;
    exp_cmd_q.push_back(8'hD1);
    exp_cmd_q.push_back(8'h91);
    exp_cmd_q.push_back(8'hB1);
    exp_cmd_q.push_back(8'hC0);
    r.x = x; r.y = y; r.z1 = z1; r.z2 = z2; r.pu = pu;
    exp_rec_q.push_back(r);
  endtask

  task automatic wait_recs(int n);
    while (n_recs < n) @(posedge clk);
  endtask

  task automatic wait_sel_low();
    do @(negedge clk); while (ssel_n);
  endtask

  task automatic idle_check(int ncyc, string req);
    int bad = 0;
    repeat (ncyc) begin
      @(negedge clk);
      if (!ssel_n) bad++;
    end
    check(req, bad, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    wait (cyc == 150000);
    n_cmp++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) chan_val[i] = 12'h0;
    exp_cmd_q.push_back(8'hD0);
    repeat (3) @(negedge clk);
    check("R1 reset select", ssel_n, 1);
    check("R1 reset clock", sck, 0);
    check("R1 reset strobe", rec_valid, 0);
    frames_on = 1;
    rst_n = 1'b1;
    while (n_frames < 1) @(posedge clk);

    // no pen: bus stays quiet
    idle_check(300, "R4 no frame while pen up");

    // scan 1, pen toggles while a frame runs
    set_vals(12'h123, 12'hABC, 12'h000, 12'hFFF);
    push_scan(12'h123, 12'hABC, 12'h000, 12'hFFF, 0);
    pen_n = 1'b0;
    wait_sel_low();
    repeat (100) @(negedge clk);
    pen_n = 1'b1;
    repeat (30) @(negedge clk);
    pen_n = 1'b0;
    wait_recs(1);
    check("R9 scan finished despite pen toggle", n_frames, 5);
    pen_n = 1'b1;
    idle_check(300, "R4 no rescan after release");
    check("R7 x held after record", rec_x, 12'h123);

    // scans 2 and 3: settle gap with pen held, then release during scan
    set_vals(12'h800, 12'h7FF, 12'h001, 12'h555);
    push_scan(12'h800, 12'h7FF, 12'h001, 12'h555, 0);
    pen_n = 1'b0;
    wait_recs(2);
    set_vals(12'h3C3, 12'hC3C, 12'hAAA, 12'h0F0);
    push_scan(12'h3C3, 12'hC3C, 12'hAAA, 12'h0F0, 1);
    wait_sel_low();
    check("R10 gap settle+1", cyc - rec_cyc, 21);
    pen_n = 1'b1;
    wait_recs(3);

    // short touch inside settle window is ignored
    repeat (2) @(negedge clk);
    pen_n = 1'b0;
    repeat (5) @(negedge clk);
    pen_n = 1'b1;
    idle_check(300, "R10 pen ignored during settle");
    check("R7 z2 held after record", rec_z2, 12'h0F0);

    // zero settle: back-to-back scans
    settle = '0;
    set_vals(12'hFFE, 12'h002, 12'h400, 12'h020);
    push_scan(12'hFFE, 12'h002, 12'h400, 12'h020, 0);
    push_scan(12'hFFE, 12'h002, 12'h400, 12'h020, 1);
    pen_n = 1'b0;
    wait_recs(4);
    wait_sel_low();
    check("R10 gap with zero settle", cyc - rec_cyc, 1);
    pen_n = 1'b1;
    wait_recs(5);
    repeat (50) @(negedge clk);

    check("R5 commands left over", exp_cmd_q.size(), 0);
    check("R7 records left over", exp_rec_q.size(), 0);
    check("R3 shortest sck phase ok", (min_run >= DIV_HALF) ? 1 : 0, 1);
    finish_run();
  end
endmodule